// File: doc/BRIEF.md
# Queued Two-Speed Bipolar Serial Word Transmitter

This block sends 32-bit avionics serial words from a small on-chip queue. A host with a 16-bit data bus builds each 31-bit word in two writes: a first strobe that carries the lower sixteen bits and a second strobe that carries the remaining fifteen bits plus a host-supplied value for bit 32. The second strobe commits the word into the next free slot of an eight-slot queue.

While the transmit enable is high and the queue holds a word, the block takes the oldest word and computes its 32nd bit. Depending on the controls, that bit is either odd or even parity over the 31 payload bits, or the host-supplied value. The block then sends the word least significant bit first on a return-to-zero bipolar pair. It supports a fast rate of ten clocks per bit and a slow rate of eighty clocks per bit. Every word is followed by a quiet gap four bit times long. A ready flag reports that the queue has drained. A self-test control routes the stream to two loopback pairs, one copy unchanged and one inverted. An asynchronous master reset stops everything and empties the queue.

The rate, bit-32 and self-test controls are static inputs, so master reset does not change them.

Top module: `a429_tx_queue`

## Requirements
- R1: A word enters the queue when a first-half strobe (`wr_lo`, carrying payload bits 15:0 on `wr_data`) is followed by a second-half strobe (`wr_hi`, carrying payload bits 30:16 on `wr_data[14:0]` and the bit-32 data value on `wr_data[15]`). The second strobe commits the word to the next free slot, and words leave in the order they were committed.
- R2: A second-half strobe with no first half pending since the last commit or reset is ignored, and no word is queued.
- R3: The queue holds at most FIFO_DEPTH (8) words. A commit while it is full is ignored, and the stored words are unchanged.
- R4: `tx_ready` is 1 exactly when the queue is empty and no word is being shifted out. It reads 1 after reset and 0 from the cycle after a commit.
- R5: With `tx_en` high and a word queued, an idle transmitter takes the head word. Its first data phase is visible no more than 2 clock cycles after `tx_en` rises.
- R6: Bits go out payload bit 0 first and bit 32 last. A one drives `line_a` high and a zero drives `line_b` high during the data phase. Both lines are low in the null phase, in the word gap and while idle, and they are never high together.
- R7: With `hi_speed`=1, each bit has 5 clocks of data phase and 5 clocks of null, and the gap after a word is 40 clocks. Both lines are therefore low for 45 clocks between the last data phase of one word and the first of the next.
- R8: With `hi_speed`=0, each bit has 40 clocks of data phase and 40 clocks of null, and the gap is 320 clocks (360 quiet clocks between words).
- R9: When `bit32_force`=1, bit 32 is parity. When `bit32_force`=0, bit 32 is parity if `par_en`=1 and the host-supplied data value if `par_en`=0.
- R10: A parity bit makes the total count of ones over payload and bit 32 odd when `par_even`=0 and even when `par_even`=1.
- R11: When `self_test_n`=0, `loop1_a`/`loop1_b` copy `line_a`/`line_b`, `loop2_a`/`loop2_b` carry the inverse (`line_b`/`line_a`), and the external lines keep transmitting. When `self_test_n`=1, all four loopback outputs are 0.
- R12: Dropping `tx_en` while a word is being shifted out abandons that word: both lines go low by the next clock, the word is lost, and the next enable starts with the following queued word.
- R13: Asserting `mrst_n` low at once forces both lines low, empties the queue, clears any pending first half and makes `tx_ready` 1. No queued word is sent after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single timing clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| wr_lo | input | 1 | First-half load strobe |
| wr_hi | input | 1 | Second-half load strobe, commits the word |
| wr_data | input | 16 | Host data bus |
| tx_en | input | 1 | Transmit enable |
| hi_speed | input | 1 | 1 selects 10-clock bits, 0 selects 80-clock bits |
| bit32_force | input | 1 | 1 forces bit 32 to parity |
| par_en | input | 1 | With bit32_force low, 1 selects parity and 0 selects host data |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| self_test_n | input | 1 | 0 enables loopback outputs |
| tx_ready | output | 1 | Queue empty and nothing shifting |
| line_a | output | 1 | Bipolar high line (ones) |
| line_b | output | 1 | Bipolar low line (zeros) |
| loop1_a | output | 1 | Loopback to receiver 1, true polarity, high side |
| loop1_b | output | 1 | Loopback to receiver 1, true polarity, low side |
| loop2_a | output | 1 | Loopback to receiver 2, inverted, high side |
| loop2_b | output | 1 | Loopback to receiver 2, inverted, low side |

## Verification
Some properties are checked on every cycle: the two lines are never high together, the lines are quiet whenever the ready flag is high or the enable was low on the previous edge, the loopback pairs track the lines, a data phase lasts more than one clock, and the queue count stays within its depth. Other behaviour only the directed scenarios can show: the exact phase and gap lengths at each rate, word order and overflow discard, the bit-32 selection and parity sense, the loss of the in-flight word when the enable drops early, and the queue contents after a master reset.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

   localparam int unsigned PAYLOAD_W = 31;
   localparam int unsigned LINE_W    = PAYLOAD_W + 1;
   localparam int unsigned BUS_W     = 16;

   typedef struct packed {
      logic                 data_bit;
      logic [PAYLOAD_W-1:0] payload;
   } slot_t;

   typedef enum logic [1:0] {
      SER_IDLE = 2'd0,
      SER_SEND = 2'd1,
      SER_GAP  = 2'd2
   } ser_state_e;

endpackage

// File: rtl/a429_half_loader.sv
module a429_half_loader
   import a429_tx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [BUS_W-1:0] wr_data,
   output logic             push,
   output slot_t            slot
);

   localparam int unsigned HI_BITS = PAYLOAD_W - BUS_W;

   logic             pend_q;
   logic [BUS_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         lo_q   <= '0;
      end else begin
         if (wr_hi && pend_q) pend_q <= 1'b0;
         if (wr_lo) begin
            pend_q <= 1'b1;
            lo_q   <= wr_data;
         end
      end
   end

   // A second half only counts when a first half is waiting.
   assign push          = wr_hi && pend_q;
   assign slot.payload  = {wr_data[HI_BITS-1:0], lo_q};
   assign slot.data_bit = wr_data[BUS_W-1];

endmodule

// File: rtl/a429_slot_fifo.sv
module a429_slot_fifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned W     = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic                       empty,
   output logic [$clog2(DEPTH+1)-1:0] count
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt_q;
   logic             full, push_ok, pop_ok;

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (push_ok && wr_ptr == PTR_W'(i)) mem[i] <= wdata;
      end
   end

   assign rdata = mem[rd_ptr];
   assign count = cnt_q;

endmodule

// File: rtl/a429_bit32_sel.sv
module a429_bit32_sel
   import a429_tx_pkg::*;
(
   input  slot_t             slot,
   input  logic              bit32_force,
   input  logic              par_en,
   input  logic              par_even,
   output logic [LINE_W-1:0] word
);

   logic ones_odd, par_bit, use_par;

   assign ones_odd = ^slot.payload;
   assign par_bit  = par_even ? ones_odd : ~ones_odd;
   assign use_par  = bit32_force || par_en;
   assign word     = {use_par ? par_bit : slot.data_bit, slot.payload};

endmodule

// File: rtl/a429_serializer.sv
module a429_serializer
   import a429_tx_pkg::*;
#(
   parameter int unsigned HS_HALF  = 5,
   parameter int unsigned LS_HALF  = 40,
   parameter int unsigned GAP_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_speed,
   input  logic              tx_en,
   input  logic              q_empty,
   input  logic [LINE_W-1:0] q_word,
   output logic              pop,
   output logic              sending,
   output logic              line_a,
   output logic              line_b
);

   localparam int unsigned MAX_HALF = (LS_HALF > HS_HALF) ? LS_HALF : HS_HALF;
   localparam int unsigned GAP_MAX  = GAP_BITS * 2 * MAX_HALF;
   localparam int unsigned CNT_W    = $clog2(GAP_MAX + 1);
   localparam int unsigned IDX_W    = $clog2(LINE_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_W - 1);

   ser_state_e        state_q;
   logic [LINE_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;
   logic              null_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  half_c, gap_c;
   logic              start, gap_done, half_done;

   assign half_c    = hi_speed ? CNT_W'(HS_HALF) : CNT_W'(LS_HALF);
   assign gap_c     = hi_speed ? CNT_W'(GAP_BITS * 2 * HS_HALF)
                               : CNT_W'(GAP_BITS * 2 * LS_HALF);
   assign start     = tx_en && !q_empty;
   assign half_done = (cnt_q == half_c - 1'b1);
   assign gap_done  = (cnt_q == gap_c - 1'b1);
   assign pop       = start && ((state_q == SER_IDLE) ||
                                (state_q == SER_GAP && gap_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SER_IDLE;
         sh_q    <= '0;
         idx_q   <= '0;
         null_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SER_IDLE: begin
               cnt_q <= '0;
               if (pop) begin
                  sh_q    <= q_word;
                  idx_q   <= '0;
                  null_q  <= 1'b0;
                  state_q <= SER_SEND;
               end
            end
            SER_SEND: begin
               if (!tx_en) begin
                  // The word in flight is abandoned.
                  state_q <= SER_IDLE;
                  cnt_q   <= '0;
                  null_q  <= 1'b0;
               end else if (half_done) begin
                  cnt_q <= '0;
                  if (!null_q) begin
                     null_q <= 1'b1;
                  end else begin
                     null_q <= 1'b0;
                     sh_q   <= sh_q >> 1;
                     if (idx_q == LAST_IDX) state_q <= SER_GAP;
                     else                   idx_q   <= idx_q + 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SER_GAP: begin
               if (!tx_en) begin
                  state_q <= SER_IDLE;
                  cnt_q   <= '0;
               end else if (gap_done) begin
                  cnt_q <= '0;
                  if (pop) begin
                     sh_q    <= q_word;
                     idx_q   <= '0;
                     null_q  <= 1'b0;
                     state_q <= SER_SEND;
                  end else begin
                     state_q <= SER_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SER_IDLE;
         endcase
      end
   end

   assign sending = (state_q == SER_SEND);
   assign line_a  = sending && !null_q &&  sh_q[0];
   assign line_b  = sending && !null_q && !sh_q[0];

endmodule

// File: rtl/a429_tx_queue.sv
module a429_tx_queue
   import a429_tx_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned HS_HALF    = 5,
   parameter int unsigned LS_HALF    = 40,
   parameter int unsigned GAP_BITS   = 4
) (
   input  logic        clk,
   input  logic        mrst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [15:0] wr_data,
   input  logic        tx_en,
   input  logic        hi_speed,
   input  logic        bit32_force,
   input  logic        par_en,
   input  logic        par_even,
   input  logic        self_test_n,
   output logic        tx_ready,
   output logic        line_a,
   output logic        line_b,
   output logic        loop1_a,
   output logic        loop1_b,
   output logic        loop2_a,
   output logic        loop2_b
);

   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("a429_tx_queue: FIFO_DEPTH must be at least 2");
      end
      if (HS_HALF < 2 || LS_HALF < HS_HALF) begin : g_bad_half
         $error("a429_tx_queue: need 2 <= HS_HALF <= LS_HALF");
      end
      if (GAP_BITS < 1) begin : g_bad_gap
         $error("a429_tx_queue: GAP_BITS must be at least 1");
      end
   endgenerate

   slot_t             in_slot, head_slot;
   logic              push, pop, q_empty, sending;
   logic [CNT_W-1:0]  q_count;
   logic [LINE_W-1:0] head_word;

   a429_half_loader u_loader (
      .clk     (clk),
      .rst_n   (mrst_n),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .push    (push),
      .slot    (in_slot)
   );

   a429_slot_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     ($bits(slot_t))
   ) u_fifo (
      .clk   (clk),
      .rst_n (mrst_n),
      .push  (push),
      .wdata (in_slot),
      .pop   (pop),
      .rdata (head_slot),
      .empty (q_empty),
      .count (q_count)
   );

   a429_bit32_sel u_bit32 (
      .slot        (head_slot),
      .bit32_force (bit32_force),
      .par_en      (par_en),
      .par_even    (par_even),
      .word        (head_word)
   );

   a429_serializer #(
      .HS_HALF  (HS_HALF),
      .LS_HALF  (LS_HALF),
      .GAP_BITS (GAP_BITS)
   ) u_ser (
      .clk      (clk),
      .rst_n    (mrst_n),
      .hi_speed (hi_speed),
      .tx_en    (tx_en),
      .q_empty  (q_empty),
      .q_word   (head_word),
      .pop      (pop),
      .sending  (sending),
      .line_a   (line_a),
      .line_b   (line_b)
   );

   assign tx_ready = (q_count == '0) && !sending;

   // Receiver 2 sees the complement: the two sides of the pair swap.
   assign loop1_a = !self_test_n && line_a;
   assign loop1_b = !self_test_n && line_b;
   assign loop2_a = !self_test_n && line_b;
   assign loop2_b = !self_test_n && line_a;

endmodule

// File: rtl/a429_tx_checker.sv
module a429_tx_checker #(
   parameter int unsigned DEPTH = 8
) (
   input logic                       clk,
   input logic                       mrst_n,
   input logic                       tx_en,
   input logic                       self_test_n,
   input logic                       tx_ready,
   input logic                       line_a,
   input logic                       line_b,
   input logic                       loop1_a,
   input logic                       loop1_b,
   input logic                       loop2_a,
   input logic                       loop2_b,
   input logic [$clog2(DEPTH+1)-1:0] q_count
);

   a_r6_lines_exclusive: assert property (@(posedge clk) disable iff (!mrst_n)
      !(line_a && line_b));

   a_r6_data_phase_holds: assert property (@(posedge clk) disable iff (!mrst_n)
      $rose(line_a) |=> line_a);

   a_r4_ready_quiet: assert property (@(posedge clk) disable iff (!mrst_n)
      tx_ready |-> (!line_a && !line_b));

   a_r12_drop_silences: assert property (@(posedge clk) disable iff (!mrst_n)
      !tx_en |=> (!line_a && !line_b));

   a_r11_loop_tracks: assert property (@(posedge clk) disable iff (!mrst_n)
      !self_test_n |-> (loop1_a == line_a && loop1_b == line_b &&
                        loop2_a == line_b && loop2_b == line_a));

   a_r11_loop_idle: assert property (@(posedge clk) disable iff (!mrst_n)
      self_test_n |-> !(loop1_a || loop1_b || loop2_a || loop2_b));

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!mrst_n)
      q_count <= ($clog2(DEPTH+1))'(DEPTH));

endmodule

bind a429_tx_queue a429_tx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk         (clk),
   .mrst_n      (mrst_n),
   .tx_en       (tx_en),
   .self_test_n (self_test_n),
   .tx_ready    (tx_ready),
   .line_a      (line_a),
   .line_b      (line_b),
   .loop1_a     (loop1_a),
   .loop1_b     (loop1_b),
   .loop2_a     (loop2_a),
   .loop2_b     (loop2_b),
   .q_count     (q_count)
);

// File: tb/a429_tx_queue_tb.sv
module a429_tx_queue_tb;

   logic        clk = 1'b0;
   logic        mrst_n = 1'b0;
   logic        wr_lo = 1'b0, wr_hi = 1'b0;
   logic [15:0] wr_data = '0;
   logic        tx_en = 1'b0, hi_speed = 1'b1;
   logic        bit32_force = 1'b1, par_en = 1'b0, par_even = 1'b0;
   logic        self_test_n = 1'b1;
   logic        tx_ready, line_a, line_b, loop1_a, loop1_b, loop2_a, loop2_b;

   int n_chk = 0;
   int n_err = 0;
   int loop_err = 0;

   always #10 clk = ~clk;

   a429_tx_queue u_dut (
      .clk(clk), .mrst_n(mrst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wr_data(wr_data), .tx_en(tx_en), .hi_speed(hi_speed),
      .bit32_force(bit32_force), .par_en(par_en), .par_even(par_even),
      .self_test_n(self_test_n), .tx_ready(tx_ready), .line_a(line_a),
      .line_b(line_b), .loop1_a(loop1_a), .loop1_b(loop1_b),
      .loop2_a(loop2_a), .loop2_b(loop2_b)
   );

   // R11 monitor: loopback pairs versus the lines on every cycle.
   always @(negedge clk) begin
      if (mrst_n) begin
         if (!self_test_n) begin
            if (loop1_a !== line_a || loop1_b !== line_b ||
                loop2_a !== line_b || loop2_b !== line_a) loop_err++;
         end else if (loop1_a || loop1_b || loop2_a || loop2_b) begin
            loop_err++;
         end
      end
   end

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [30:0] p, input logic d);
      logic b;
      if (bit32_force || par_en) b = par_even ? ^p : ~^p;
      else                       b = d;
      return {b, p};
   endfunction

   task automatic load_word(input logic [30:0] p, input logic d);
      @(negedge clk);
      wr_lo = 1'b1; wr_data = p[15:0];
      @(negedge clk);
      wr_lo = 1'b0; wr_hi = 1'b1; wr_data = {d, p[30:16]};
      @(negedge clk);
      wr_hi = 1'b0; wr_data = '0;
   endtask

   // Decodes one word from the lines, sampling at falling edges.
   task automatic capture(input int half, input int wait_lim,
                          output logic [31:0] w, output int got,
                          output int bad, output int tail);
      int t = 0;
      w = '0; got = 0; bad = 0; tail = 0;
      while (!(line_a || line_b) && t < wait_lim) begin
         @(negedge clk); t++;
      end
      if (!(line_a || line_b)) return;
      for (int i = 0; i < 32; i++) begin
         int hi = 0;
         int lo = 0;
         int lim = (i == 31) ? 12 * half : 2 * half + 2;
         w[i] = line_a;
         while ((line_a || line_b) && hi < 1000) begin
            hi++; @(negedge clk);
         end
         if (hi != half) bad++;
         while (!(line_a || line_b) && lo < lim) begin
            lo++; @(negedge clk);
         end
         got = i + 1;
         if (i == 31) tail = lo;
         else if (lo != half) begin
            bad++;
            if (lo >= lim) return;
         end
      end
   endtask

   task automatic t_reset();
      mrst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(tx_ready === 1'b1, "R4 ready after reset", 32'(tx_ready), 32'd1);
      chk(!line_a && !line_b, "R13 lines low in reset", {line_a, line_b}, 0);
      mrst_n = 1'b1;
      @(negedge clk);
      chk(!(loop1_a || loop1_b || loop2_a || loop2_b), "R11 loops idle",
          {loop1_a, loop1_b, loop2_a, loop2_b}, 0);
   endtask

   task automatic t_single_hs();
      logic [31:0] w; int got, bad, tail, t;
      logic [30:0] p = 31'h2A5C_3E91;
      load_word(p, 1'b0);
      chk(tx_ready === 1'b0, "R4 ready low after commit", 32'(tx_ready), 0);
      tx_en = 1'b1;
      t = 0;
      while (!(line_a || line_b) && t < 50) begin
         @(negedge clk); t++;
      end
      chk(t <= 2, "R5 first bit latency", t, 2);
      capture(5, 10, w, got, bad, tail);
      chk(got == 32 && w == exp_word(p, 1'b0), "R6 word content", w, exp_word(p, 1'b0));
      chk(bad == 0, "R7 fast bit timing", bad, 0);
      chk(tx_ready === 1'b1, "R4 ready after drain", 32'(tx_ready), 1);
      tx_en = 1'b0;
   endtask

   task automatic send_one(input logic [30:0] p, input logic d, input string req);
      logic [31:0] w; int got, bad, tail;
      load_word(p, d);
      tx_en = 1'b1;
      capture(5, 20, w, got, bad, tail);
      chk(got == 32 && w == exp_word(p, d), req, w, exp_word(p, d));
      tx_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_bit32_modes();
      bit32_force = 1'b0; par_en = 1'b0;
      send_one(31'h0000_0003, 1'b1, "R9 data bit one");
      send_one(31'h0000_0001, 1'b0, "R9 data bit zero");
      par_en = 1'b1; par_even = 1'b1;
      send_one(31'h0000_0007, 1'b0, "R9 R10 parity selected even");
      bit32_force = 1'b1; par_en = 1'b0; par_even = 1'b0;
      send_one(31'h0000_0006, 1'b0, "R10 odd parity");
      par_even = 1'b1;
      send_one(31'h1234_5671, 1'b0, "R10 even parity");
      par_even = 1'b0;
   endtask

   task automatic t_order_gap();
      logic [31:0] w; int got, bad, tail;
      logic [30:0] ps [3] = '{31'h0111_1111, 31'h7EDC_BA98, 31'h0000_ABCD};
      for (int i = 0; i < 3; i++) load_word(ps[i], 1'b0);
      tx_en = 1'b1;
      for (int i = 0; i < 3; i++) begin
         capture(5, 20, w, got, bad, tail);
         chk(w == exp_word(ps[i], 1'b0), "R1 queue order", w, exp_word(ps[i], 1'b0));
         if (i < 2) chk(tail == 45, "R7 fast word gap", tail, 45);
      end
      tx_en = 1'b0;
   endtask

   task automatic t_full();
      logic [31:0] w; int got, bad, tail;
      for (int i = 0; i < 10; i++) load_word(31'(i * 31'h0123_4567 + 1), 1'b0);
      tx_en = 1'b1;
      for (int i = 0; i < 8; i++) begin
         capture(5, 20, w, got, bad, tail);
         chk(w == exp_word(31'(i * 31'h0123_4567 + 1), 1'b0), "R3 stored word",
             w, exp_word(31'(i * 31'h0123_4567 + 1), 1'b0));
      end
      chk(tail == 60, "R3 no ninth word", tail, 60);
      chk(tx_ready === 1'b1, "R3 R4 drained", 32'(tx_ready), 1);
      tx_en = 1'b0;
   endtask

   task automatic t_half_only();
      int pulses = 0;
      @(negedge clk);
      wr_hi = 1'b1; wr_data = 16'h7FFF;
      @(negedge clk);
      wr_hi = 1'b0; wr_data = '0;
      chk(tx_ready === 1'b1, "R2 lone second half", 32'(tx_ready), 1);
      tx_en = 1'b1;
      repeat (30) begin
         @(negedge clk);
         if (line_a || line_b) pulses++;
      end
      chk(pulses == 0, "R2 nothing sent", pulses, 0);
      tx_en = 1'b0;
   endtask

   task automatic t_low_speed();
      logic [31:0] w; int got, bad, tail;
      hi_speed = 1'b0;
      load_word(31'h5555_0F0F, 1'b0);
      load_word(31'h0A0A_F0F0, 1'b0);
      tx_en = 1'b1;
      capture(40, 20, w, got, bad, tail);
      chk(w == exp_word(31'h5555_0F0F, 1'b0), "R8 slow word", w, exp_word(31'h5555_0F0F, 1'b0));
      chk(bad == 0, "R8 slow bit timing", bad, 0);
      chk(tail == 360, "R8 slow word gap", tail, 360);
      capture(40, 20, w, got, bad, tail);
      chk(w == exp_word(31'h0A0A_F0F0, 1'b0), "R8 second slow word", w, exp_word(31'h0A0A_F0F0, 1'b0));
      tx_en = 1'b0;
      hi_speed = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_drop();
      logic [31:0] w; int got, bad, tail;
      load_word(31'h3333_3333, 1'b0);
      load_word(31'h0C0C_0C0C, 1'b0);
      tx_en = 1'b1;
      repeat (60) @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk(!line_a && !line_b, "R12 lines low after drop", {line_a, line_b}, 0);
      repeat (5) @(negedge clk);
      chk(tx_ready === 1'b0, "R12 next word still queued", 32'(tx_ready), 0);
      tx_en = 1'b1;
      capture(5, 20, w, got, bad, tail);
      chk(w == exp_word(31'h0C0C_0C0C, 1'b0), "R12 in-flight word lost", w, exp_word(31'h0C0C_0C0C, 1'b0));
      tx_en = 1'b0;
   endtask

   task automatic t_reset_mid();
      int pulses = 0;
      for (int i = 0; i < 3; i++) load_word(31'h0F00_0001 + 31'(i), 1'b0);
      tx_en = 1'b1;
      repeat (30) @(negedge clk);
      mrst_n = 1'b0;
      #1;
      chk(!line_a && !line_b, "R13 reset silences", {line_a, line_b}, 0);
      chk(tx_ready === 1'b1, "R13 reset empties", 32'(tx_ready), 1);
      @(negedge clk);
      mrst_n = 1'b1;
      repeat (60) begin
         @(negedge clk);
         if (line_a || line_b) pulses++;
      end
      chk(pulses == 0, "R13 queue cleared", pulses, 0);
      tx_en = 1'b0;
   endtask

   task automatic t_self_test();
      logic [31:0] w; int got, bad, tail;
      self_test_n = 1'b0;
      load_word(31'h6B1D_4C27, 1'b0);
      tx_en = 1'b1;
      capture(5, 20, w, got, bad, tail);
      chk(w == exp_word(31'h6B1D_4C27, 1'b0), "R11 lines active in self-test",
          w, exp_word(31'h6B1D_4C27, 1'b0));
      tx_en = 1'b0;
      self_test_n = 1'b1;
      @(negedge clk);
      chk(loop_err == 0, "R11 loopback mismatches", loop_err, 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_single_hs();
      t_bit32_modes();
      t_order_gap();
      t_full();
      t_half_only();
      t_low_speed();
      t_drop();
      t_reset_mid();
      t_self_test();
      finish_run();
   end

endmodule